// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. Every line is first captured in a request register, either on a rising edge or by following its level. A per-line mask blocks a line from being serviced, and an in-service register records which levels the processor is currently handling. A fixed-priority resolver looks at all three registers and raises the interrupt output only when an unmasked pending level outranks everything already in service. Level 0 has the highest priority and level 7 the lowest.

The processor answers the interrupt with two active-low acknowledge pulses. On the first pulse the controller picks the winning level, sets its in-service bit and clears its request bit. During the second pulse it drives an 8-bit vector onto the read data bus. The vector has a programmed 5-bit base in bits 7:3 and the level index in bits 2:0. Software uses a small port with chip select, read strobe and write strobe, all active low. Through this port it loads the mask, the trigger mode and the vector base, reads back the request and in-service registers, and issues end-of-interrupt commands.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `int_out` and `dout_en` are 0, the mask reads 0xFF (all levels masked), the mode reads 0x00 (level trigger), the base reads 0x00, and the request and in-service registers read 0x00.
- R2: The port takes exactly one write per falling write strobe while `cs_n` is low, and ignores writes while `cs_n` is high. A read with `cs_n` and `rd_n` low sets `dout_en` and returns a register selected by `addr`: 0 is the mask, 1 is the mode (bit 0 only), 2 is the base (bits 7:3, low bits read 0), 3 is the request register and 4 is the in-service register.
- R3: A mask bit of 1 stops its level from raising `int_out` or being granted. The request bit is still recorded and is serviced once the level is unmasked.
- R4: With mode bit 0 set to 1 (edge trigger), a request bit is set on a 0-to-1 input transition. It stays set after the input falls, until the level is granted. An input held high after its grant does not set the bit again.
- R5: With mode bit 0 set to 0 (level trigger), a request bit follows its input, so a request that drops before acknowledge is lost.
- R6: `int_out` is 1 exactly when the lowest-index unmasked pending level has a lower index than every in-service level, or when no level is in service.
- R7: On the first falling edge of `inta_n`, the winning level's in-service bit is set and its request bit is cleared, and `int_out` falls.
- R8: From the second falling edge of `inta_n` until `inta_n` rises, `dout_en` is 1 and `dout` equals {base, 3-bit level index}. After `inta_n` rises, `dout_en` returns to 0.
- R9: If no level is eligible at the first pulse, the vector uses level index 7 and the in-service register does not change.
- R10: A write to address 3 (end of interrupt, any data) clears only the lowest-index set bit of the in-service register.
- R11: A higher-priority request that arrives while a level is in service raises `int_out` again, which nests the service. A lower-priority request waits until end of interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, bit 0 highest priority |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| addr | input | 3 | Register select |
| din | input | 8 | Write data |
| inta_n | input | 1 | Interrupt acknowledge, active low |
| dout | output | 8 | Read data or interrupt vector |
| dout_en | output | 1 | High while `dout` carries a read or a vector |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The bench runs a fixed directed sequence first. A masked request checks that it is recorded but stays silent. Lower-priority and higher-priority requests arriving against an active service level separate nesting from waiting. An acknowledge with no eligible request exercises the spurious case. The same input held high is tried in edge and level trigger modes, which shows whether capture follows transitions or follows the input. A randomized phase then pulses random request patterns under random masks and vector bases. It serves every grant and end of interrupt against a bench model, so grant order, vector contents and the interrupt output are all compared against expected values over many mixtures of pending, masked and in-service levels.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_MODE = 3'd1,
    SEL_BASE = 3'd2,
    SEL_CMD  = 3'd3,   // write: end of interrupt, read: request register
    SEL_SVC  = 3'd4    // read: in-service register
  } reg_sel_e;
endpackage

// File: rtl/pic_prio_pick.sv
// Fixed-priority picker: lowest index wins.
module pic_prio_pick #(
  parameter int N_LVL = 8,
  localparam int IDX_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic [N_LVL-1:0] vec,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_LVL-1:0] onehot
);
  logic [N_LVL:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N_LVL; g++) begin : g_chain
      assign seen[g+1]  = seen[g] | vec[g];
      assign onehot[g]  = vec[g] & ~seen[g];
    end
  endgenerate

  assign any = seen[N_LVL];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_req_track.sv
// Request register with edge or level capture (R4, R5).
module pic_req_track #(
  parameter int N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_in,
  input  logic             edge_mode,
  input  logic [N_LVL-1:0] grant,
  output logic [N_LVL-1:0] irr
);
  logic [N_LVL-1:0] irq_q;
  logic [N_LVL-1:0] irr_q;
  logic [N_LVL-1:0] irr_d;
  logic [N_LVL-1:0] rise;

  always_comb begin
    rise = irq_in & ~irq_q;
    if (edge_mode) begin
      irr_d = (irr_q & ~grant) | rise;
    end else begin
      irr_d = irq_in & ~grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_in;
      irr_q <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/pic_reg_port.sv
// Software register port (R2, R10).
module pic_reg_port
  import pic_pkg::*;
#(
  parameter int N_LVL = 8,
  localparam int IDX_W  = (N_LVL > 1) ? $clog2(N_LVL) : 1,
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [N_LVL-1:0]  irr,
  input  logic [N_LVL-1:0]  isr,
  output logic [N_LVL-1:0]  mask,
  output logic              edge_mode,
  output logic [BASE_W-1:0] base,
  output logic              eoi_fire,
  output logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic              wstb;
  logic              wstb_q;
  logic              wr_fire;
  logic              mask_we;
  logic              mode_we;
  logic              base_we;
  logic [N_LVL-1:0]  mask_q;
  logic              edge_q;
  logic [BASE_W-1:0] base_q;

  always_comb begin
    wstb     = ~cs_n & ~wr_n;
    wr_fire  = wstb & ~wstb_q;
    mask_we  = wr_fire && (addr == SEL_MASK);
    mode_we  = wr_fire && (addr == SEL_MODE);
    base_we  = wr_fire && (addr == SEL_BASE);
    eoi_fire = wr_fire && (addr == SEL_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_q <= 1'b0;
      mask_q <= '1;
      edge_q <= 1'b0;
      base_q <= '0;
    end else begin
      wstb_q <= wstb;
      if (mask_we) mask_q <= din[N_LVL-1:0];
      if (mode_we) edge_q <= din[0];
      if (base_we) base_q <= din[DATA_W-1:IDX_W];
    end
  end

  always_comb begin
    rd_en = ~cs_n & ~rd_n;
    case (addr)
      SEL_MASK: rd_data = DATA_W'(mask_q);
      SEL_MODE: rd_data = DATA_W'(edge_q);
      SEL_BASE: rd_data = {base_q, {IDX_W{1'b0}}};
      SEL_CMD:  rd_data = DATA_W'(irr);
      SEL_SVC:  rd_data = DATA_W'(isr);
      default:  rd_data = '0;
    endcase
  end

  assign mask      = mask_q;
  assign edge_mode = edge_q;
  assign base      = base_q;
endmodule

// File: rtl/pic_ack_seq.sv
// Two-pulse acknowledge sequencer (R7, R8, R9).
module pic_ack_seq #(
  parameter int N_LVL = 8,
  localparam int IDX_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inta_n,
  input  logic             int_req,
  input  logic [N_LVL-1:0] pend_onehot,
  input  logic [IDX_W-1:0] pend_idx,
  output logic [N_LVL-1:0] grant,
  output logic [IDX_W-1:0] vec_lvl,
  output logic             vec_active
);
  logic             inta_q;
  logic             phase_q;
  logic             phase_d;
  logic [IDX_W-1:0] lvl_q;
  logic [IDX_W-1:0] lvl_d;
  logic             lvl_we;
  logic             vec_q;
  logic             vec_d;
  logic             fall;
  logic             first_fall;
  logic             second_fall;

  always_comb begin
    fall        = inta_q & ~inta_n;
    first_fall  = fall & ~phase_q;
    second_fall = fall & phase_q;
    phase_d     = phase_q;
    if (first_fall)  phase_d = 1'b1;
    if (second_fall) phase_d = 1'b0;
    lvl_we = first_fall;
    lvl_d  = int_req ? pend_idx : IDX_W'(N_LVL - 1);
    grant  = (first_fall && int_req) ? pend_onehot : '0;
    if (second_fall)  vec_d = 1'b1;
    else if (inta_n)  vec_d = 1'b0;
    else              vec_d = vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q  <= 1'b1;
      phase_q <= 1'b0;
      lvl_q   <= '0;
      vec_q   <= 1'b0;
    end else begin
      inta_q  <= inta_n;
      phase_q <= phase_d;
      vec_q   <= vec_d;
      if (lvl_we) lvl_q <= lvl_d;
    end
  end

  assign vec_lvl    = lvl_q;
  assign vec_active = vec_q;
endmodule

// File: rtl/pic_ctrl.sv
// Top: request/mask/in-service tracking with fixed priority (R6, R10, R11).
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int N_LVL = 8,
  localparam int IDX_W  = (N_LVL > 1) ? $clog2(N_LVL) : 1,
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LVL-1:0]  irq_in,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              inta_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              int_out
);
  logic [N_LVL-1:0]  irr_w;
  logic [N_LVL-1:0]  mask_w;
  logic [N_LVL-1:0]  pend;
  logic [N_LVL-1:0]  grant_w;
  logic [N_LVL-1:0]  isr_q;
  logic [N_LVL-1:0]  isr_d;
  logic [N_LVL-1:0]  eoi_clr;
  logic [N_LVL-1:0]  pend_oh;
  logic [N_LVL-1:0]  isr_oh;
  logic [IDX_W-1:0]  pend_idx;
  logic [IDX_W-1:0]  isr_idx;
  logic [IDX_W-1:0]  vec_lvl;
  logic [BASE_W-1:0] base_w;
  logic [DATA_W-1:0] rd_data;
  logic              pend_any;
  logic              isr_any;
  logic              edge_mode;
  logic              eoi_fire;
  logic              rd_en;
  logic              vec_active_w;
  logic              int_req;

  pic_reg_port #(.N_LVL(N_LVL)) u_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .irr(irr_w), .isr(isr_q),
    .mask(mask_w), .edge_mode(edge_mode), .base(base_w),
    .eoi_fire(eoi_fire), .rd_en(rd_en), .rd_data(rd_data)
  );

  pic_req_track #(.N_LVL(N_LVL)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(edge_mode),
    .grant(grant_w), .irr(irr_w)
  );

  assign pend = irr_w & ~mask_w;

  pic_prio_pick #(.N_LVL(N_LVL)) u_pick_pend (
    .vec(pend), .any(pend_any), .idx(pend_idx), .onehot(pend_oh)
  );

  pic_prio_pick #(.N_LVL(N_LVL)) u_pick_svc (
    .vec(isr_q), .any(isr_any), .idx(isr_idx), .onehot(isr_oh)
  );

  // R6: raise only above everything in service
  assign int_req = pend_any & (~isr_any | (pend_idx < isr_idx));

  pic_ack_seq #(.N_LVL(N_LVL)) u_ack (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .int_req(int_req),
    .pend_onehot(pend_oh), .pend_idx(pend_idx),
    .grant(grant_w), .vec_lvl(vec_lvl), .vec_active(vec_active_w)
  );

  // R10: end of interrupt drops the highest-priority service bit
  always_comb begin
    eoi_clr = eoi_fire ? isr_oh : '0;
    isr_d   = (isr_q & ~eoi_clr) | grant_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  always_comb begin
    if (vec_active_w)  dout = {base_w, vec_lvl};
    else if (rd_en)    dout = rd_data;
    else               dout = '0;
    dout_en = vec_active_w | rd_en;
  end

  assign int_out = int_req;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N_LVL = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             inta_n,
  input logic             int_out,
  input logic [N_LVL-1:0] irr,
  input logic [N_LVL-1:0] isr,
  input logic [N_LVL-1:0] mask,
  input logic             vec_active
);
  logic [N_LVL-1:0] pend;
  logic [N_LVL-1:0] low_svc;
  logic [N_LVL-1:0] above_svc;

  always_comb begin
    pend      = irr & ~mask;
    low_svc   = isr & (~isr + 1'b1);
    above_svc = low_svc - 1'b1;
  end

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (pend != '0));

  a_r6_above_service: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((isr == '0) || ((pend & above_svc) != '0)));

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr & ~$past(isr)) <= 1));

  a_r10_single_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(isr) & ~isr) <= 1));

  a_r8_vector_release: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_active && inta_n) |=> !vec_active);

  a_r2_mask_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(mask));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .inta_n(inta_n), .int_out(int_out),
  .irr(irr_w), .isr(isr_q), .mask(mask_w), .vec_active(vec_active_w)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
  logic       clk;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       cs_n, rd_n, wr_n, inta_n;
  logic [2:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_en;
  logic       int_out;

  int checks;
  int fails;
  bit done;

  logic [7:0] m_irr, m_isr, m_mask;
  logic [4:0] m_base;

  pic_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .din(din), .inta_n(inta_n),
    .dout(dout), .dout_en(dout_en), .int_out(int_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int lowidx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int(input logic [7:0] irr, input logic [7:0] isr,
                                   input logic [7:0] msk);
    int p, s;
    p = lowidx(irr & ~msk);
    s = lowidx(isr);
    return (p < 8) && (p < s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    d = dout;
    if (dout_en !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R2 read enable actual=%0b expected=1", dout_en);
    end
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ack(output logic [7:0] v, output logic en, output logic en_after);
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); inta_n = 1'b1;
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); #1;
    v = dout; en = dout_en;
    inta_n = 1'b1;
    @(negedge clk); #1;
    en_after = dout_en;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk);
  endtask

  task automatic int_chk(input string req, input logic exp);
    @(negedge clk); #1;
    chk(req, int_out, exp);
  endtask

  task automatic ack_chk(input string req, input logic [7:0] exp_vec);
    logic [7:0] v;
    logic en, en2;
    ack(v, en, en2);
    chk(req, v, exp_vec);
    chk("R8 vector enable", en, 1'b1);
    chk("R8 vector release", en2, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    checks = 0; fails = 0; done = 0;
    irq_in = 8'h00; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
    addr = 3'd0; din = 8'h00; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 int_out", int_out, 1'b0);
    chk("R1 dout_en", dout_en, 1'b0);
    rst_n = 1'b1;
    rchk("R1 mask", 3'd0, 8'hFF);
    rchk("R1 mode", 3'd1, 8'h00);
    rchk("R1 base", 3'd2, 8'h00);
    rchk("R1 irr",  3'd3, 8'h00);
    rchk("R1 isr",  3'd4, 8'h00);

    // R2 register port
    wr(3'd2, 8'hAD, 1);
    rchk("R2 base low bits zero", 3'd2, 8'hA8);
    wr(3'd1, 8'hFF, 1);
    rchk("R2 mode bit0 only", 3'd1, 8'h01);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 3'd0; din = 8'h00;
    @(negedge clk); wr_n = 1'b1;
    rchk("R2 write ignored without select", 3'd0, 8'hFF);

    // R3 masked request recorded but silent
    pulse(8'h10);
    int_chk("R3 masked int_out", 1'b0);
    rchk("R3 masked still recorded", 3'd3, 8'h10);
    wr(3'd0, 8'h00, 1);
    int_chk("R3 unmasked raises", 1'b1);

    // R7 / R8 grant
    ack_chk("R8 vector level 4", 8'hAC);
    rchk("R7 isr set", 3'd4, 8'h10);
    rchk("R7 irr cleared", 3'd3, 8'h00);
    int_chk("R7 int_out dropped", 1'b0);

    // R6 / R11 nesting
    pulse(8'h40);
    int_chk("R6 lower waits", 1'b0);
    pulse(8'h02);
    int_chk("R11 higher nests", 1'b1);
    ack_chk("R11 vector level 1", 8'hA9);
    rchk("R11 isr nested", 3'd4, 8'h12);
    wr(3'd3, 8'h00, 1);
    rchk("R10 eoi clears lowest", 3'd4, 8'h10);
    int_chk("R6 still below service", 1'b0);
    wr(3'd3, 8'h00, 4);
    rchk("R2 held strobe one eoi", 3'd4, 8'h00);
    int_chk("R11 waiting level raises", 1'b1);
    ack_chk("R11 vector level 6", 8'hAE);
    wr(3'd3, 8'h00, 1);
    rchk("R10 eoi empty", 3'd4, 8'h00);

    // R9 spurious
    ack_chk("R9 spurious vector", 8'hAF);
    rchk("R9 isr unchanged", 3'd4, 8'h00);

    // R4 edge with held input
    @(negedge clk); irq_in = 8'h04;
    int_chk("R4 rise captured", 1'b1);
    ack_chk("R4 vector level 2", 8'hAA);
    rchk("R4 held input no re-set", 3'd3, 8'h00);
    wr(3'd3, 8'h00, 1);
    int_chk("R4 no second request", 1'b0);
    @(negedge clk); irq_in = 8'h00;

    // R5 level mode
    wr(3'd1, 8'h00, 1);
    @(negedge clk); irq_in = 8'h08;
    int_chk("R5 level raises", 1'b1);
    rchk("R5 irr follows", 3'd3, 8'h08);
    @(negedge clk); irq_in = 8'h00;
    int_chk("R5 level dropped", 1'b0);
    rchk("R5 irr cleared", 3'd3, 8'h00);

    // Random phase, edge mode
    wr(3'd1, 8'h01, 1);
    m_irr = 8'h00; m_isr = 8'h00; m_mask = 8'h00;
    for (int it = 0; it < 40; it++) begin
      logic [7:0] pat;
      m_base = 5'($urandom);
      m_mask = 8'($urandom);
      pat    = 8'($urandom);
      wr(3'd2, {m_base, 3'b000}, 1);
      wr(3'd0, m_mask, 1);
      pulse(pat);
      m_irr = m_irr | pat;
      int_chk("R6 random int_out", exp_int(m_irr, m_isr, m_mask));
      for (int st = 0; st < 24; st++) begin
        if (exp_int(m_irr, m_isr, m_mask)) begin
          int w;
          w = lowidx(m_irr & ~m_mask);
          ack_chk("R8 random vector", {m_base, 3'(w)});
          m_isr[w] = 1'b1;
          m_irr[w] = 1'b0;
        end else if (m_isr != 8'h00) begin
          wr(3'd3, 8'h00, 1);
          m_isr[lowidx(m_isr)] = 1'b0;
        end else begin
          break;
        end
        int_chk("R6 random after step", exp_int(m_irr, m_isr, m_mask));
      end
      rchk("R3 random irr", 3'd3, m_irr);
      rchk("R10 random isr", 3'd4, m_isr);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule